// File: doc/BRIEF.md
# Low-Side Switch Fault Diagnostics (four channels)

This block holds the digital diagnostic logic for a bank of low-side power switches. Each channel takes an active-low on/off command and four comparator flags that are already synchronized: overcurrent, overtemperature, drain below the ground-short threshold, and load current below the open-load reference. From these it drives the gate enable of its power stage and keeps a two-bit fault code. The code sits in the low bits of a per-channel status byte, where the serial readout logic picks it up.

A channel turns its stage off at once when overtemperature is flagged. It also turns the stage off when overcurrent persists for a number of timebase ticks. After such a trip the stage stays off until the command has gone to off and come back to on. Ground shorts count only while the stage is commanded off. Open load counts only while the stage is conducting. These two checks share one dwell counter, and it restarts on every command transition. An open load that clears by itself while the stage is still on is recorded at once. One that is still present when the stage is turned off is recorded at that turn-off.

Faults are merged by rank, so a more severe fault overwrites a milder one and never the reverse. A readout clear empties the code. Any fault detected in the same cycle as the clear is kept.

Top module: `lsd_quad_diag`

## Requirements
- R1: A high `ctl_n` bit (off) sampled at a clock edge makes that channel's `gate_en` low after that edge. A low bit makes it high after that edge, unless the channel is tripped.
- R2: Overcurrent held while the channel is commanded on trips the channel once it has lasted OC_TICKS ticks. `gate_en` falls one edge after the count is reached and the code becomes 11. A shorter burst has no effect.
- R3: Overtemperature while the channel is commanded on drops `gate_en` after the next edge and stores code 11.
- R4: A trip keeps `gate_en` low for as long as `ctl_n` stays low, even after the flags clear. At least one edge with `ctl_n` high, followed by `ctl_n` low, turns the stage back on.
- R5: A ground-short flag held while the channel is commanded off stores code 10 one edge after FILT_TICKS ticks. A shorter flag, or a flag seen while commanded on, stores nothing.
- R6: An open-load flag qualifies only while `gate_en` is high and only after FILT_TICKS ticks. Qualifying alone stores nothing, and the flag has no effect while the channel is off.
- R7: A qualified open load that is still flagged when `ctl_n` rises stores code 01 in the edge that samples `ctl_n` high.
- R8: A qualified open load whose flag drops while the stage is still on stores code 01 at the next edge.
- R9: The stored code is the larger of the held code and the code of this cycle's event. A lower-ranked fault never replaces a higher one.
- R10: A one-cycle `rd_clr` pulse replaces the code with the code of that cycle's event, which is 00 when there is none.
- R11: While `rst` is high, every `gate_en` is low and every status byte is zero from the first edge on.
- R12: Filter counters advance only on edges where `tick` is high.
- R13: Channels are independent. Status byte i carries the code in its bits [1:0], and bits [7:2] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (external or undervoltage) |
| tick | input | 1 | Filter timebase strobe |
| ctl_n | input | CH | Active-low on command per channel; high (pulled up when open) means off |
| oc_flag | input | CH | Overcurrent comparator flag |
| ot_flag | input | CH | Overtemperature flag |
| scg_flag | input | CH | Drain below ground-short threshold |
| ol_flag | input | CH | Load current below open-load reference |
| rd_clr | input | CH | Readout clear pulse per channel |
| gate_en | output | CH | Power stage gate enable |
| status | output | 8*CH | Status bytes; byte i bits [1:0] hold the fault code (00 none, 01 open load, 10 ground short, 11 overcurrent/overtemperature) |

## Verification
The command path has one register stage, so `gate_en` follows `ctl_n` one edge later, and an overtemperature trip also lands one edge later. A filtered fault lands one edge after its counter reaches its limit. That is OC_TICKS+1 edges after overcurrent starts and FILT_TICKS+1 edges after a ground short starts. An open load that qualified is written one edge after its flag drops or after `ctl_n` rises. The bench drives inputs on falling edges and counts rising edges exactly. At each boundary it reads outputs one edge before the due cycle, expecting nothing yet, and then in the due cycle, expecting the result. A near-exhaustive sweep over pairs of fault kinds compares the merged code with the arithmetic maximum.

// File: rtl/lsd_diag_pkg.sv
`timescale 1ns/1ps
package lsd_diag_pkg;

    localparam int STATUS_W = 8;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_OPEN  = 2'b01,
        FC_GND   = 2'b10,
        FC_OVER  = 2'b11
    } fcode_t;

    typedef struct packed {
        logic over;
        logic gnd;
        logic open;
    } fevt_t;

    function automatic fcode_t evt_code(fevt_t e);
        if (e.over)      return FC_OVER;
        else if (e.gnd)  return FC_GND;
        else if (e.open) return FC_OPEN;
        return FC_NONE;
    endfunction

    function automatic fcode_t rank_merge(fcode_t held, fcode_t fresh, logic clr);
        if (clr) return fresh;
        return (fresh > held) ? fresh : held;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(fcode_t c);
        return {{(STATUS_W-2){1'b0}}, c};
    endfunction

endpackage

// File: rtl/lsd_dwell_filter.sv
`timescale 1ns/1ps
module lsd_dwell_filter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    input  logic restart,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !cond)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign hit = cond && (cnt == LIM);
endmodule

// File: rtl/lsd_chan_diag.sv
`timescale 1ns/1ps
module lsd_chan_diag
    import lsd_diag_pkg::*;
#(
    parameter int OC_TICKS   = 8,
    parameter int FILT_TICKS = 62
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   ctl_n,
    input  logic   oc,
    input  logic   ot,
    input  logic   scg,
    input  logic   ol,
    input  logic   clr,
    output logic   gate_en,
    output fcode_t code
);
    logic   ctl_q;
    logic   trip;
    logic   ol_pend;
    fcode_t code_q;

    logic cmd_on, ctl_edge, turning_off, gate_on;
    logic oc_hit, sh_cond, sh_hit, ol_write;
    fevt_t evt;

    assign cmd_on      = ~ctl_q;
    assign ctl_edge    = ctl_n ^ ctl_q;
    assign turning_off = ctl_edge & ctl_n;
    assign gate_on     = cmd_on & ~trip;

    // Overcurrent dwell: counts only while commanded on with the flag up
    lsd_dwell_filter #(.LIMIT(OC_TICKS)) oc_filt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cond    (cmd_on & oc),
        .restart (1'b0),
        .hit     (oc_hit)
    );

    // Shared dwell for ground short (off) and open load (conducting)
    assign sh_cond = gate_on ? ol : (~cmd_on & scg);

    lsd_dwell_filter #(.LIMIT(FILT_TICKS)) sh_filt_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cond    (sh_cond),
        .restart (ctl_edge),
        .hit     (sh_hit)
    );

    assign ol_write = ol_pend & ((gate_on & ~ol & ~ctl_edge) | turning_off);

    always_comb begin
        evt      = '0;
        evt.over = cmd_on & (oc_hit | ot);
        evt.gnd  = ~cmd_on & sh_hit;
        evt.open = ol_write;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= 1'b1;
            trip    <= 1'b0;
            ol_pend <= 1'b0;
            code_q  <= FC_NONE;
        end else begin
            ctl_q <= ctl_n;
            if (!cmd_on)
                trip <= 1'b0;
            else if (oc_hit || ot)
                trip <= 1'b1;
            if (ol_write)
                ol_pend <= 1'b0;
            else if (gate_on && sh_hit)
                ol_pend <= 1'b1;
            code_q <= rank_merge(code_q, evt_code(evt), clr);
        end
    end

    assign gate_en = gate_on;
    assign code    = code_q;
endmodule

// File: rtl/lsd_quad_diag.sv
`timescale 1ns/1ps
module lsd_quad_diag
    import lsd_diag_pkg::*;
#(
    parameter int CH         = 4,
    parameter int OC_TICKS   = 8,
    parameter int FILT_TICKS = 62
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [CH-1:0]          ctl_n,
    input  logic [CH-1:0]          oc_flag,
    input  logic [CH-1:0]          ot_flag,
    input  logic [CH-1:0]          scg_flag,
    input  logic [CH-1:0]          ol_flag,
    input  logic [CH-1:0]          rd_clr,
    output logic [CH-1:0]          gate_en,
    output logic [STATUS_W*CH-1:0] status
);
    for (genvar i = 0; i < CH; i++) begin : g_ch
        fcode_t ch_code;

        lsd_chan_diag #(
            .OC_TICKS   (OC_TICKS),
            .FILT_TICKS (FILT_TICKS)
        ) chan_i (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .ctl_n   (ctl_n[i]),
            .oc      (oc_flag[i]),
            .ot      (ot_flag[i]),
            .scg     (scg_flag[i]),
            .ol      (ol_flag[i]),
            .clr     (rd_clr[i]),
            .gate_en (gate_en[i]),
            .code    (ch_code)
        );

        assign status[STATUS_W*i +: STATUS_W] = pack_status(ch_code);
    end
endmodule

// File: rtl/lsd_quad_diag_chk.sv
`timescale 1ns/1ps
module lsd_quad_diag_chk #(
    parameter int CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [CH-1:0]   ctl_n,
    input logic [CH-1:0]   ot_flag,
    input logic [CH-1:0]   rd_clr,
    input logic [CH-1:0]   gate_en,
    input logic [8*CH-1:0] status
);
    logic rst_d = 1'b0;

    always_ff @(posedge clk) rst_d <= rst;

    // R11
    always_ff @(posedge clk) begin
        if (rst_d) begin
            reset_quiet_chk: assert (gate_en == '0 && status == '0);
        end
    end

    for (genvar i = 0; i < CH; i++) begin : g_chk
        // R1
        off_gate_chk: assert property (@(posedge clk) disable iff (rst)
            $past(ctl_n[i]) |-> !gate_en[i]);

        // R3
        ot_cut_chk: assert property (@(posedge clk) disable iff (rst)
            (gate_en[i] && ot_flag[i]) |=> !gate_en[i]);

        // R4
        trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !gate_en[i] && !$past(ctl_n[i]) && !ctl_n[i]) |=> !gate_en[i]);

        // R9
        code_rank_chk: assert property (@(posedge clk) disable iff (rst)
            !rd_clr[i] |=> (status[8*i +: 2] >= $past(status[8*i +: 2])));
    end
endmodule

bind lsd_quad_diag lsd_quad_diag_chk #(.CH(CH)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ctl_n   (ctl_n),
    .ot_flag (ot_flag),
    .rd_clr  (rd_clr),
    .gate_en (gate_en),
    .status  (status)
);

// File: tb/lsd_quad_diag_tb_top.sv
`timescale 1ns/1ps
module lsd_quad_diag_tb_top;
    localparam int CH   = 4;
    localparam int OCT  = 2;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic [CH-1:0] ctl_n = '1;
    logic [CH-1:0] oc_flag = '0, ot_flag = '0, scg_flag = '0, ol_flag = '0, rd_clr = '0;
    logic [CH-1:0] gate_en;
    logic [8*CH-1:0] status;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lsd_quad_diag #(.CH(CH), .OC_TICKS(OCT), .FILT_TICKS(FILT)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .ctl_n(ctl_n), .oc_flag(oc_flag),
        .ot_flag(ot_flag), .scg_flag(scg_flag), .ol_flag(ol_flag),
        .rd_clr(rd_clr), .gate_en(gate_en), .status(status)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(int ch);
        return int'(status[8*ch +: 2]);
    endfunction

    task automatic do_reset();
        rst = 1'b1; ctl_n = '1; oc_flag = '0; ot_flag = '0;
        scg_flag = '0; ol_flag = '0; rd_clr = '0; tick = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic mk_ol(int ch);
        ctl_n[ch] = 1'b0; cyc(2);
        ol_flag[ch] = 1'b1; cyc(FILT + 1);
        ol_flag[ch] = 1'b0; cyc(1);
        ctl_n[ch] = 1'b1; cyc(2);
    endtask

    task automatic mk_scg(int ch);
        scg_flag[ch] = 1'b1; cyc(FILT + 1);
        scg_flag[ch] = 1'b0; cyc(1);
    endtask

    task automatic mk_scb(int ch);
        ctl_n[ch] = 1'b0; cyc(2);
        ot_flag[ch] = 1'b1; cyc(1);
        ot_flag[ch] = 1'b0;
        ctl_n[ch] = 1'b1; cyc(2);
    endtask

    task automatic mk_fault(int ch, int c);
        case (c)
            1: mk_ol(ch);
            2: mk_scg(ch);
            3: mk_scb(ch);
            default: ;
        endcase
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset with stage commanded on
        ctl_n = '0;
        cyc(2);
        chk("R11 gate in reset", int'(gate_en), 0);
        chk("R11 status in reset", int'(status), 0);
        do_reset();

        // R1: command follows after one edge
        ctl_n[0] = 1'b0; cyc(1);
        chk("R1 on", int'(gate_en[0]), 1);
        ctl_n[0] = 1'b1; cyc(1);
        chk("R1 off", int'(gate_en[0]), 0);

        // R2: short overcurrent burst ignored
        ctl_n[0] = 1'b0; cyc(2);
        oc_flag[0] = 1'b1; cyc(OCT - 1);
        oc_flag[0] = 1'b0; cyc(3);
        chk("R2 short burst gate", int'(gate_en[0]), 1);
        chk("R2 short burst code", code_of(0), 0);
        // R2: sustained overcurrent
        oc_flag[0] = 1'b1; cyc(OCT);
        chk("R2 before limit gate", int'(gate_en[0]), 1);
        chk("R2 before limit code", code_of(0), 0);
        cyc(1);
        chk("R2 trip gate", int'(gate_en[0]), 0);
        chk("R2 trip code", code_of(0), 3);
        // R4: latched while command stays on
        oc_flag[0] = 1'b0; cyc(4);
        chk("R4 latched", int'(gate_en[0]), 0);
        ctl_n[0] = 1'b1; cyc(1);
        ctl_n[0] = 1'b0; cyc(1);
        chk("R4 recycle", int'(gate_en[0]), 1);

        // R3: overtemperature immediate
        do_reset();
        ctl_n[1] = 1'b0; cyc(2);
        ot_flag[1] = 1'b1; cyc(1);
        chk("R3 gate", int'(gate_en[1]), 0);
        chk("R3 code", code_of(1), 3);
        ot_flag[1] = 1'b0;
        ctl_n[1] = 1'b1; cyc(2);

        // R5: ground short filter
        do_reset();
        scg_flag[0] = 1'b1; cyc(FILT);
        chk("R5 before limit", code_of(0), 0);
        cyc(1);
        chk("R5 stored", code_of(0), 2);
        scg_flag[0] = 1'b0; cyc(1);
        // R13: other channels untouched, upper bits zero
        chk("R13 others", int'(status[31:8]), 0);
        chk("R13 upper bits", int'(status[7:2]), 0);
        // R10: clear with simultaneous event keeps it
        scg_flag[0] = 1'b1; cyc(FILT + 2);
        rd_clr[0] = 1'b1; cyc(1);
        rd_clr[0] = 1'b0;
        chk("R10 clear with event", code_of(0), 2);
        scg_flag[0] = 1'b0; cyc(1);
        rd_clr[0] = 1'b1; cyc(1);
        rd_clr[0] = 1'b0;
        chk("R10 clear empties", code_of(0), 0);
        // R5: glitch shorter than filter
        scg_flag[0] = 1'b1; cyc(FILT);
        scg_flag[0] = 1'b0; cyc(3);
        chk("R5 glitch", code_of(0), 0);
        // R5: while commanded on
        ctl_n[0] = 1'b0; cyc(1);
        scg_flag[0] = 1'b1; cyc(FILT + 3);
        chk("R5 while on", code_of(0), 0);
        scg_flag[0] = 1'b0;
        ctl_n[0] = 1'b1; cyc(2);

        // R6: open load while off ignored
        ol_flag[2] = 1'b1; cyc(FILT + 3);
        ol_flag[2] = 1'b0; cyc(2);
        chk("R6 while off", code_of(2), 0);
        // R7: static open load written at turn-off
        ctl_n[2] = 1'b0; cyc(2);
        ol_flag[2] = 1'b1; cyc(FILT + 1);
        cyc(3);
        chk("R6 qualified not stored", code_of(2), 0);
        ctl_n[2] = 1'b1; cyc(1);
        chk("R7 static", code_of(2), 1);
        ol_flag[2] = 1'b0; cyc(1);

        // R8: sporadic open load written on flag drop
        do_reset();
        ctl_n[3] = 1'b0; cyc(2);
        ol_flag[3] = 1'b1; cyc(FILT + 1);
        chk("R8 pending", code_of(3), 0);
        ol_flag[3] = 1'b0; cyc(1);
        chk("R8 sporadic", code_of(3), 1);
        ctl_n[3] = 1'b1; cyc(2);

        // R12: no ticks, no progress
        do_reset();
        tick = 1'b0;
        scg_flag[1] = 1'b1; cyc(FILT + 6);
        chk("R12 frozen", code_of(1), 0);
        tick = 1'b1; cyc(FILT);
        chk("R12 before limit", code_of(1), 0);
        cyc(1);
        chk("R12 resumed", code_of(1), 2);
        scg_flag[1] = 1'b0;

        // R11: reset mid-operation
        ctl_n[1] = 1'b0; cyc(2);
        rst = 1'b1; cyc(1);
        chk("R11 gate", int'(gate_en[1]), 0);
        chk("R11 code", code_of(1), 0);
        cyc(2);
        chk("R11 held", int'(gate_en[1]), 0);
        rst = 1'b0; cyc(1);
        chk("R1 after reset", int'(gate_en[1]), 1);
        ctl_n[1] = 1'b1; cyc(2);

        // R9: rank merge sweep over ordered fault pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 1; b < 4; b++) begin
                int ch = (a + b) % CH;
                do_reset();
                mk_fault(ch, a);
                chk("R9 first", code_of(ch), a);
                mk_fault(ch, b);
                chk("R9 merged", code_of(ch), (a > b) ? a : b);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule